// File: doc/BRIEF.md
# Reset and Startup Vector Sequencer

This block produces the internal reset of a small 8-bit core from two causes: an active-low reset pin from the board and a one-cycle timeout pulse from the watchdog. The pin is first brought into the clock domain by a short flop chain. It then has to stay low for a minimum number of clock samples before it is accepted as a reset, so narrow glitches leave a running core alone.

After the cause goes away, the core stays held while the oscillator settles. This wait is a fixed count of main clocks, 262144 by default (about 65.5 ms at 4 MHz). A seven-cycle startup sequence follows. In its last two cycles the block reads the two-byte start vector over the core's data bus and assembles the program counter start value.

While the core is held, the block drives a bundle of initialization strobes into the core's register file. When the sequence completes, it raises a sticky running flag and a one-cycle load pulse for the program counter. A watchdog pulse during the settle wait or the vector reads restarts the sequence at the settle wait. Memory contents are outside this block and are never touched.

Top module: `boot_reset_seq`

## Requirements
- R1: A low level on `rst_pin_n` that lasts fewer than MIN_LOW (8) consecutive clock samples is ignored: `running` stays 1 and `core_rst` stays 0.
- R2: A low level on `rst_pin_n` that lasts MIN_LOW or more samples is taken as a reset. Within three clocks of the pin returning high, `running` is 0 and `core_rst` is 1.
- R3: Edge 1 is the first rising clock edge that samples `rst_pin_n` high after a taken pin reset. `running` becomes 1 after edge STAB_CYCLES+11.
- R4: `vec_rd` is high for exactly two cycles per startup: the second-to-last cycle of the sequence with `vec_addr` = 16'hFFFE, then the last cycle with `vec_addr` = 16'hFFFF.
- R5: In the first cycle with `running` = 1, `start_pc` equals {byte read at 16'hFFFF, byte read at 16'hFFFE} and `pc_load` is 1. `pc_load` is 0 in the next cycle, and it never pulses for a sequence that a watchdog pulse cut short.
- R6: Edge 1 is the edge that samples `wdt_trip` high, whatever the state, provided the pin is not held low. `running` becomes 1 after edge STAB_CYCLES+8.
- R7: `core_rst` is always the inverse of `running`. Once set, `running` stays 1 until a watchdog pulse or a taken pin reset.
- R8: All six bits of `init_vec` are 1 while the core is held in reset or in the settle wait, and all are 0 during the vector reads and while running. The bits are: [0] clear RAM page register, [1] clear G flag, [2] peripheral clock on, [3] supply-voltage detector on, [4] voltage booster off, [5] select main clock.
- R9: While `por_n` is low, `core_rst` = 1, `running` = 0, `vec_rd` = 0, `pc_load` = 0 and `start_pc` = 0. With the pin high, `running` becomes 1 after edge STAB_CYCLES+8, counted from the first edge after `por_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Asynchronous clear of the sequencer flops at power-up |
| rst_pin_n | input | 1 | Raw external reset pin, active low, asynchronous |
| wdt_trip | input | 1 | Watchdog timeout pulse, one clock wide |
| bus_rdata | input | DATA_W | Read data returned for `vec_addr` in the same cycle |
| core_rst | output | 1 | Reset held on the core |
| running | output | 1 | Startup finished; core is executing |
| init_vec | output | 6 | Register initialization strobes (see R8) |
| vec_addr | output | ADDR_W | Address of the vector byte being read |
| vec_rd | output | 1 | Vector read strobe |
| start_pc | output | ADDR_W | Assembled program counter start value |
| pc_load | output | 1 | One-cycle pulse to load `start_pc` into the program counter |

## Verification
Each result arrives a fixed number of edges after its cause. A pin release reaches `running` after STAB_CYCLES+11 edges: two synchronizer flops, one for the width counter, one for the state register, the settle count and the seven sequence cycles. A watchdog pulse reaches it after STAB_CYCLES+8 edges, because the pulse enters the state register directly. The bench drives and samples on the falling edge and counts edges from the stimulus. It checks the latency, the two read cycles at that latency minus two and minus one, the strobe edges at minus eight and minus seven, and the outcome of a pin reset at edge three. A small settle count lets it sweep every glitch width below the threshold, several widths above it, and a watchdog pulse at every cycle offset inside the settle wait and the vector reads.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [1:0] {
      SQ_HOLD  = 2'd0,
      SQ_STAB  = 2'd1,
      SQ_FETCH = 2'd2,
      SQ_RUN   = 2'd3
   } seq_state_t;

   localparam int INIT_W        = 6;
   localparam int INIT_PAGE_CLR = 0;
   localparam int INIT_GFLG_CLR = 1;
   localparam int INIT_PCLK_ON  = 2;
   localparam int INIT_SVD_ON   = 3;
   localparam int INIT_BOOST_OFF = 4;
   localparam int INIT_MAINCLK  = 5;

endpackage

// File: rtl/pin_width_filter.sv
module pin_width_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 8
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic pin_held
);
   localparam int CNT_W = $clog2(MIN_LOW + 1);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_LOW);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pin_width_filter: SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW < 2) begin : g_bad_low
      $error("pin_width_filter: MIN_LOW must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic [CNT_W-1:0]       low_cnt;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= pin_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             low_cnt <= '0;
      else if (pin_s)         low_cnt <= '0;
      else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
   end

   assign pin_held = (low_cnt == SAT);

   AST_HELD_AFTER_LOW: assert property (@(posedge clk) disable iff (!por_n) $rose(pin_held) |-> $past(!pin_s)); // R2
   AST_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!por_n) pin_s |=> !pin_held); // R1

endmodule

// File: rtl/stab_timer.sv
module stab_timer #(
   parameter int STAB_CYCLES = 262144
) (
   input  logic clk,
   input  logic por_n,
   input  logic clear,
   input  logic run,
   output logic done
);
   localparam int W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
   localparam logic [W-1:0] TERM = W'(STAB_CYCLES - 1);
   localparam bit POW2 = ((STAB_CYCLES & (STAB_CYCLES - 1)) == 0);

   if (STAB_CYCLES < 2) begin : g_bad_len
      $error("stab_timer: STAB_CYCLES must be at least 2");
   end

   logic [W-1:0] cnt;
   logic         at_term;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                 cnt <= '0;
      else if (clear)             cnt <= '0;
      else if (run && !at_term)   cnt <= cnt + 1'b1;
   end

   if (POW2) begin : g_pow2
      assign at_term = &cnt;
   end else begin : g_cmp
      assign at_term = (cnt == TERM);
   end

   assign done = run && at_term;

   AST_STAB_SATURATES: assert property (@(posedge clk) disable iff (!por_n) (run && !clear && cnt == TERM) |=> cnt == TERM); // R3
   AST_STAB_NO_EARLY: assert property (@(posedge clk) disable iff (!por_n) done |-> $past(run)); // R3

endmodule

// File: rtl/vector_fetch.sv
module vector_fetch #(
   parameter int FETCH_LEN = 7,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter logic [ADDR_W-1:0] VEC_LO = 16'hFFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              active,
   input  logic              abort,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              vec_rd,
   output logic [ADDR_W-1:0] start_pc,
   output logic              pc_load,
   output logic              done
);
   localparam int SW = $clog2(FETCH_LEN);
   localparam logic [SW-1:0] LAST = SW'(FETCH_LEN - 1);
   localparam logic [SW-1:0] LO_STEP = SW'(FETCH_LEN - 2);
   localparam logic [ADDR_W-1:0] VEC_HI = VEC_LO + 1'b1;

   if (FETCH_LEN < 3) begin : g_bad_len
      $error("vector_fetch: FETCH_LEN must be at least 3");
   end
   if (ADDR_W != 2 * DATA_W) begin : g_bad_w
      $error("vector_fetch: ADDR_W must be twice DATA_W");
   end

   logic [SW-1:0]     step;
   logic [DATA_W-1:0] lo_q, hi_q;
   logic              rd_lo, rd_hi;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        step <= '0;
      else if (!active)  step <= '0;
      else if (step != LAST) step <= step + 1'b1;
   end

   assign rd_lo    = active && (step == LO_STEP);
   assign rd_hi    = active && (step == LAST);
   assign vec_rd   = rd_lo || rd_hi;
   assign vec_addr = (step == LAST) ? VEC_HI : VEC_LO;
   assign done     = rd_hi && !abort;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         pc_load <= 1'b0;
      end else begin
         if (rd_lo) lo_q <= bus_rdata;
         if (rd_hi) hi_q <= bus_rdata;
         pc_load <= done;
      end
   end

   assign start_pc = {hi_q, lo_q};

   AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!por_n) (vec_rd && vec_addr == VEC_HI) |-> ($past(vec_rd) && $past(vec_addr) == VEC_LO)); // R4
   AST_PCLOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n) pc_load |=> !pc_load); // R5
   AST_PCLOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!por_n) pc_load |-> $past(vec_rd)); // R5

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
   import boot_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 8,
   parameter int STAB_CYCLES = 262144,
   parameter int FETCH_LEN   = 7,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter logic [ADDR_W-1:0] VEC_LO = 16'hFFFE
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   input  logic              wdt_trip,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              core_rst,
   output logic              running,
   output logic [INIT_W-1:0] init_vec,
   output logic [ADDR_W-1:0] vec_addr,
   output logic              vec_rd,
   output logic [ADDR_W-1:0] start_pc,
   output logic              pc_load
);
   seq_state_t st, st_nxt;
   logic pin_held, stab_done, fetch_done, restart, running_q;

   assign restart = wdt_trip || pin_held;

   pin_width_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .MIN_LOW    (MIN_LOW)
   ) i_filter (
      .clk     (clk),
      .por_n   (por_n),
      .pin_n   (rst_pin_n),
      .pin_held(pin_held)
   );

   stab_timer #(
      .STAB_CYCLES(STAB_CYCLES)
   ) i_stab (
      .clk  (clk),
      .por_n(por_n),
      .clear((st != SQ_STAB) || wdt_trip),
      .run  (st == SQ_STAB),
      .done (stab_done)
   );

   vector_fetch #(
      .FETCH_LEN(FETCH_LEN),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .VEC_LO   (VEC_LO)
   ) i_fetch (
      .clk      (clk),
      .por_n    (por_n),
      .active   (st == SQ_FETCH),
      .abort    (restart),
      .bus_rdata(bus_rdata),
      .vec_addr (vec_addr),
      .vec_rd   (vec_rd),
      .start_pc (start_pc),
      .pc_load  (pc_load),
      .done     (fetch_done)
   );

   always_comb begin
      st_nxt = st;
      unique case (st)
         SQ_HOLD:  if (!pin_held)  st_nxt = SQ_STAB;
         SQ_STAB:  if (stab_done)  st_nxt = SQ_FETCH;
         SQ_FETCH: if (fetch_done) st_nxt = SQ_RUN;
         SQ_RUN:   st_nxt = SQ_RUN;
         default:  st_nxt = SQ_HOLD;
      endcase
      if (wdt_trip) st_nxt = SQ_STAB;
      if (pin_held) st_nxt = SQ_HOLD;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st <= SQ_HOLD;
      else        st <= st_nxt;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          running_q <= 1'b0;
      else if (restart)    running_q <= 1'b0;
      else if (fetch_done) running_q <= 1'b1;
   end

   assign running  = running_q;
   assign core_rst = (st != SQ_RUN);
   assign init_vec = {INIT_W{(st == SQ_HOLD) || (st == SQ_STAB)}};

   AST_RUN_XOR_RST: assert property (@(posedge clk) disable iff (!por_n) running != core_rst); // R7
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!por_n) (running && !wdt_trip && !pin_held) |=> running); // R7
   AST_INIT_ONLY_IN_RST: assert property (@(posedge clk) disable iff (!por_n) (|init_vec) |-> (core_rst && !vec_rd)); // R8
   AST_WDT_DROPS_RUN: assert property (@(posedge clk) disable iff (!por_n) wdt_trip |=> !running); // R6
   AST_PIN_DROPS_RUN: assert property (@(posedge clk) disable iff (!por_n) pin_held |=> (!running && init_vec == '1)); // R2

endmodule

// File: tb/test_boot_reset_seq.sv
module test_boot_reset_seq;
   localparam int STAB = 20;
   localparam int MINL = 8;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_pin_n = 1'b1;
   logic        wdt_trip = 1'b0;
   logic [7:0]  bus_rdata;
   logic        core_rst, running, vec_rd, pc_load;
   logic [5:0]  init_vec;
   logic [15:0] vec_addr, start_pc;
   logic [7:0]  lo_pat = 8'h00, hi_pat = 8'h00;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   assign bus_rdata = (vec_addr == 16'hFFFE) ? lo_pat : (vec_addr == 16'hFFFF) ? hi_pat : 8'h00;

   boot_reset_seq #(
      .MIN_LOW    (MINL),
      .STAB_CYCLES(STAB)
   ) i_boot_reset_seq (
      .clk      (clk),
      .por_n    (por_n),
      .rst_pin_n(rst_pin_n),
      .wdt_trip (wdt_trip),
      .bus_rdata(bus_rdata),
      .core_rst (core_rst),
      .running  (running),
      .init_vec (init_vec),
      .vec_addr (vec_addr),
      .vec_rd   (vec_rd),
      .start_pc (start_pc),
      .pc_load  (pc_load)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // Count edges from the stimulus until running is set, then check the read cycles, strobes and load pulse
   task automatic run_phase(input int exp_n, input string req, input bit from_pin);
      int n = 0;
      int rds = 0;
      int rd1 = -1;
      int rd2 = -1;
      logic [15:0] a1 = '0, a2 = '0;
      bit inv_ok = 1'b1;
      do begin
         tick();
         n++;
         if (vec_rd) begin
            rds++;
            if (rds == 1) begin rd1 = n; a1 = vec_addr; end
            else if (rds == 2) begin rd2 = n; a2 = vec_addr; end
         end
         if (core_rst == running) inv_ok = 1'b0;
         if (from_pin && n == 3) chk(!running && core_rst, "R2 pin reset taken", {running, core_rst}, 2'b01);
         if (n == exp_n - 8) chk(init_vec == 6'h3F, "R8 strobes in settle wait", init_vec, 6'h3F);
         if (n == exp_n - 7) chk(init_vec == 6'h00, "R8 strobes off in reads", init_vec, 6'h00);
      end while (!(running && n > 3) && n < exp_n + 20);
      chk(n == exp_n, {req, " latency to running"}, n, exp_n);
      chk(rds == 2 && rd1 == exp_n - 2 && rd2 == exp_n - 1, "R4 read cycles", {rd1[15:0], rd2[15:0]}, {16'(exp_n - 2), 16'(exp_n - 1)});
      chk(a1 == 16'hFFFE && a2 == 16'hFFFF, "R4 read addresses", {a1, a2}, 32'hFFFEFFFF);
      chk(start_pc == {hi_pat, lo_pat}, "R5 start value", start_pc, {hi_pat, lo_pat});
      chk(pc_load == 1'b1, "R5 load pulse", pc_load, 1);
      chk(inv_ok, "R7 core_rst inverse of running", inv_ok, 1);
      tick();
      chk(!pc_load && running, "R5 pulse ends, R7 running kept", {pc_load, running}, 2'b01);
   endtask

   task automatic pulse_wdt();
      wdt_trip = 1'b1;
      tick();
      wdt_trip = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog timeout: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) tick();
      // R9: state while power-up clear is applied
      chk(core_rst && !running && !vec_rd && !pc_load && start_pc == 16'h0, "R9 reset state",
          {core_rst, running, vec_rd, pc_load, start_pc}, {4'b1000, 16'h0});
      chk(init_vec == 6'h3F, "R8 strobes during power-up", init_vec, 6'h3F);
      lo_pat = 8'h34;
      hi_pat = 8'h12;
      por_n = 1'b1;
      run_phase(STAB + 8, "R9", 1'b0);

      // R1: every glitch width below the threshold
      for (int w = 1; w < MINL; w++) begin
         bit ok = 1'b1;
         rst_pin_n = 1'b0;
         repeat (w) tick();
         rst_pin_n = 1'b1;
         repeat (12) begin
            tick();
            if (!running || core_rst) ok = 1'b0;
         end
         chk(ok, "R1 short low ignored", w, 0);
      end

      // R2, R3: widths at and above the threshold
      for (int w = MINL; w <= MINL + 4; w++) begin
         lo_pat = 8'(w * 29 + 3);
         hi_pat = 8'(8'hA0 ^ w);
         rst_pin_n = 1'b0;
         repeat (w) tick();
         rst_pin_n = 1'b1;
         run_phase(STAB + 11, "R3", 1'b1);
      end

      // R6: watchdog while running
      lo_pat = 8'h5A;
      hi_pat = 8'hC3;
      pulse_wdt();
      run_phase(STAB + 7, "R6", 1'b0);

      // R6, R5: second watchdog at every offset inside settle wait and reads
      for (int k = 0; k <= STAB + 6; k++) begin
         int loads = 0;
         pulse_wdt();
         repeat (k) begin
            tick();
            if (pc_load) loads++;
         end
         lo_pat = 8'(k * 37 + 5);
         hi_pat = 8'(~(k * 11));
         pulse_wdt();
         if (pc_load) loads++;
         chk(loads == 0, "R5 no load on cut sequence", loads, 0);
         run_phase(STAB + 7, "R6", 1'b0);
      end

      // R2, R3: pin reset taken in the middle of the settle wait
      pulse_wdt();
      repeat (3) tick();
      lo_pat = 8'hE7;
      hi_pat = 8'h81;
      rst_pin_n = 1'b0;
      repeat (MINL) tick();
      rst_pin_n = 1'b1;
      run_phase(STAB + 11, "R3", 1'b1);

      // R7: running persists with no cause
      begin
         bit ok = 1'b1;
         repeat (50) begin
            tick();
            if (!running || core_rst || init_vec != 6'h00) ok = 1'b0;
         end
         chk(ok, "R7 running sticky", running, 1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule